// File: doc/BRIEF.md
# Test Access Port with Debug Register Access

This block is a boundary-test style access port controller clocked by the test clock. It holds the standard sixteen-state controller, a 4-bit instruction register and a small set of data registers: a one-bit bypass stage, a fixed 32-bit identification word, a 32-bit user code that can be read and rewritten, and a debug path into an internal register file.

A debug access takes two instructions. The address instruction shifts an 8-bit target address into a holding register. A following debug-write or debug-read instruction then uses that address. A write reaches the register file on the Update-DR step. A read is taken from it on the Capture-DR step and then shifted out. Two addresses are served inside the block and never reach the file port. 0x0B returns the identification word. 0x0C is the user code, which can be read or written there.

Instruction codes with no data register here (external test, sample/preload, configuration write, internal test, the two user chains, high-impedance and all spare codes) fall through to the bypass stage. The register file port is a plain single-cycle strobe interface in the test-clock domain.

Top module: `dbg_tap_top`

## Requirements
- R1: With trst_n low, or after five test clocks with tms high, the controller is in Test-Logic-Reset. The current instruction is then the identification instruction (0x7), so a 32-bit data scan returns 0x00000675 LSB first.
- R2: Capture-IR loads binary 0001, so the first four bits shifted out of the instruction register are 1,0,0,0. The current instruction changes only on Update-IR or in Test-Logic-Reset.
- R3: Instruction 0xF selects a one-bit bypass stage that captures 0 and delays tdi by one test clock.
- R4: Codes 0x0, 0x1, 0x2, 0x6, 0x9, 0xA, 0xB, 0xC, 0xD and 0xE behave exactly as bypass.
- R5: Instruction 0x8 selects the 32-bit user code. It resets to 0xFFFFFFFF, captures its current value and takes the shifted value on Update-DR.
- R6: Instruction 0x5 selects an 8-bit address register. It captures the address held now and loads the shifted value on Update-DR.
- R7: Instruction 0x3 with a held address other than 0x0B and 0x0C raises dbg_wr_en for exactly the one Update-DR cycle. During that cycle dbg_addr is the held address and dbg_wdata is the shifted word.
- R8: Instruction 0x4 with a held address other than 0x0B and 0x0C raises dbg_rd_en for exactly the one Capture-DR cycle. The scan then returns dbg_rdata as sampled in that cycle, LSB first.
- R9: With the held address 0x0B a debug read returns 0x00000675 and a debug write has no effect. With 0x0C a debug read returns the user code and a debug write replaces it. In neither case does the file port strobe.
- R10: tdo changes only on the falling test-clock edge. tdo_oe is high only in Shift-IR and Shift-DR, and tdo is 0 whenever tdo_oe is low.
- R11: dbg_wr_en and dbg_rd_en are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | High while tdo carries shift data |
| dbg_wr_en | output | 1 | Register file write strobe |
| dbg_rd_en | output | 1 | Register file read strobe |
| dbg_addr | output | 8 | Register file address |
| dbg_wdata | output | 32 | Register file write data |
| dbg_rdata | input | 32 | Register file read data |

## Verification
A wrong controller state or a stale instruction shows up within the next scan. The wrong chain length or capture value appears as a shifted or misplaced bit pattern on tdo, and an output enable outside the shift states shows on tdo_oe in the same half clock. A wrong held address or a misrouted internal target shows in the Update-DR or Capture-DR cycle of the very access. It appears as a strobe that should not be there, a missing strobe, or a wrong address on the file port. It also shows on the read scan that follows.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;
  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    SEL_BYPASS, SEL_IDCODE, SEL_USERCODE, SEL_DBG_ADDR, SEL_DBG_WR, SEL_DBG_RD
  } dr_sel_e;

  localparam logic [IR_W-1:0] OP_DBG_WR   = 4'h3;
  localparam logic [IR_W-1:0] OP_DBG_RD   = 4'h4;
  localparam logic [IR_W-1:0] OP_DBG_ADDR = 4'h5;
  localparam logic [IR_W-1:0] OP_IDCODE   = 4'h7;
  localparam logic [IR_W-1:0] OP_USERCODE = 4'h8;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;
endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
  import dbg_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= state_d;
  end

  // R1: tms held high keeps the controller in Test-Logic-Reset
  p_tlr_sticky_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR && tms) |=> (state == ST_TLR));
endmodule

// File: rtl/dbg_tap_ir.sv
module dbg_tap_ir
  import dbg_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_e state,
  output logic       ir_tdo,
  output dr_sel_e    dr_sel
);
  logic [IR_W-1:0] ir_sh, ir_sh_d;
  logic [IR_W-1:0] ir_q, ir_q_d;

  always_comb begin
    ir_sh_d = ir_sh;
    ir_q_d  = ir_q;
    case (state)
      ST_CAP_IR: ir_sh_d = IR_CAPTURE;
      ST_SHF_IR: ir_sh_d = {tdi, ir_sh[IR_W-1:1]};
      ST_UPD_IR: ir_q_d  = ir_sh;
      ST_TLR:    ir_q_d  = OP_IDCODE;
      default: ;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= IR_CAPTURE;
      ir_q  <= OP_IDCODE;
    end else begin
      ir_sh <= ir_sh_d;
      ir_q  <= ir_q_d;
    end
  end

  assign ir_tdo = ir_sh[0];

  always_comb begin
    case (ir_q)
      OP_IDCODE:   dr_sel = SEL_IDCODE;
      OP_USERCODE: dr_sel = SEL_USERCODE;
      OP_DBG_ADDR: dr_sel = SEL_DBG_ADDR;
      OP_DBG_WR:   dr_sel = SEL_DBG_WR;
      OP_DBG_RD:   dr_sel = SEL_DBG_RD;
      default:     dr_sel = SEL_BYPASS;
    endcase
  end

  // R1: Test-Logic-Reset leaves the identification chain selected
  p_id_after_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR) |=> (dr_sel == SEL_IDCODE));
  // R2: the current instruction moves only on Update-IR or Test-Logic-Reset
  p_ir_hold_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_UPD_IR && state != ST_TLR) |=> $stable(dr_sel));
endmodule

// File: rtl/dbg_tap_dr.sv
module dbg_tap_dr
  import dbg_tap_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] ID_WORD = 32'h0000_0675,
  parameter logic [31:0] UC_INIT = 32'hFFFF_FFFF,
  parameter int          ID_ADDR = 8'h0B,
  parameter int          UC_ADDR = 8'h0C
)(
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  tap_state_e        state,
  input  dr_sel_e           dr_sel,
  output logic              dr_tdo,
  output logic              dbg_wr_en,
  output logic              dbg_rd_en,
  output logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_wdata,
  input  logic [DATA_W-1:0] dbg_rdata
);
  localparam logic [ADDR_W-1:0] A_ID = ADDR_W'(ID_ADDR);
  localparam logic [ADDR_W-1:0] A_UC = ADDR_W'(UC_ADDR);
  localparam logic [DATA_W-1:0] V_ID = DATA_W'(ID_WORD);
  localparam logic [DATA_W-1:0] V_UC = DATA_W'(UC_INIT);

  logic              byp_q, byp_d;
  logic [ADDR_W-1:0] addr_sh, addr_sh_d, addr_q, addr_q_d;
  logic [DATA_W-1:0] data_sh, data_sh_d, uc_q, uc_d;
  logic              cap, shf, upd, tgt_id, tgt_uc, tgt_ext, wide_sel;

  assign cap      = (state == ST_CAP_DR);
  assign shf      = (state == ST_SHF_DR);
  assign upd      = (state == ST_UPD_DR);
  assign tgt_id   = (addr_q == A_ID);
  assign tgt_uc   = (addr_q == A_UC);
  assign tgt_ext  = !(tgt_id || tgt_uc);
  assign wide_sel = (dr_sel == SEL_IDCODE) || (dr_sel == SEL_USERCODE) ||
                    (dr_sel == SEL_DBG_WR) || (dr_sel == SEL_DBG_RD);

  assign dbg_rd_en = cap && (dr_sel == SEL_DBG_RD) && tgt_ext;
  assign dbg_wr_en = upd && (dr_sel == SEL_DBG_WR) && tgt_ext;
  assign dbg_addr  = addr_q;
  assign dbg_wdata = data_sh;

  always_comb begin
    byp_d     = byp_q;
    addr_sh_d = addr_sh;
    addr_q_d  = addr_q;
    data_sh_d = data_sh;
    uc_d      = uc_q;
    case (dr_sel)
      SEL_BYPASS: begin
        if (cap)      byp_d = 1'b0;
        else if (shf) byp_d = tdi;
      end
      SEL_DBG_ADDR: begin
        if (cap)      addr_sh_d = addr_q;
        else if (shf) addr_sh_d = {tdi, addr_sh[ADDR_W-1:1]};
        else if (upd) addr_q_d  = addr_sh;
      end
      default: ;
    endcase
    if (wide_sel) begin
      if (cap) begin
        case (dr_sel)
          SEL_IDCODE:   data_sh_d = V_ID;
          SEL_USERCODE: data_sh_d = uc_q;
          SEL_DBG_RD:   data_sh_d = tgt_id ? V_ID : (tgt_uc ? uc_q : dbg_rdata);
          default:      data_sh_d = '0;
        endcase
      end else if (shf) begin
        data_sh_d = {tdi, data_sh[DATA_W-1:1]};
      end else if (upd) begin
        if (dr_sel == SEL_USERCODE || (dr_sel == SEL_DBG_WR && tgt_uc)) uc_d = data_sh;
      end
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q   <= 1'b0;
      addr_sh <= '0;
      addr_q  <= '0;
      data_sh <= '0;
      uc_q    <= V_UC;
    end else begin
      byp_q   <= byp_d;
      addr_sh <= addr_sh_d;
      addr_q  <= addr_q_d;
      data_sh <= data_sh_d;
      uc_q    <= uc_d;
    end
  end

  always_comb begin
    case (dr_sel)
      SEL_BYPASS:   dr_tdo = byp_q;
      SEL_DBG_ADDR: dr_tdo = addr_sh[0];
      default:      dr_tdo = data_sh[0];
    endcase
  end

  // R5: the user code moves only on Update-DR
  p_uc_stable_r5: assert property (@(posedge tck) disable iff (!trst_n)
    !upd |=> $stable(uc_q));
  // R6: the held address moves only on Update-DR
  p_addr_stable_r6: assert property (@(posedge tck) disable iff (!trst_n)
    !upd |=> $stable(dbg_addr));
  // R7: one write strobe per update
  p_wr_pulse_r7: assert property (@(posedge tck) disable iff (!trst_n)
    dbg_wr_en |=> !dbg_wr_en);
  // R8: one read strobe per capture
  p_rd_pulse_r8: assert property (@(posedge tck) disable iff (!trst_n)
    dbg_rd_en |=> !dbg_rd_en);
  // R11: strobes are exclusive
  p_excl_strobe_r11: assert property (@(posedge tck) disable iff (!trst_n)
    !(dbg_wr_en && dbg_rd_en));
endmodule

// File: rtl/dbg_tap_top.sv
module dbg_tap_top
  import dbg_tap_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] ID_WORD = 32'h0000_0675,
  parameter logic [31:0] UC_INIT = 32'hFFFF_FFFF
)(
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  output logic              dbg_wr_en,
  output logic              dbg_rd_en,
  output logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_wdata,
  input  logic [DATA_W-1:0] dbg_rdata
);
  tap_state_e state;
  dr_sel_e    dr_sel;
  logic       ir_tdo, dr_tdo, shifting, tdo_d;

  dbg_tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  dbg_tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
    .ir_tdo(ir_tdo), .dr_sel(dr_sel)
  );

  dbg_tap_dr #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_WORD(ID_WORD), .UC_INIT(UC_INIT)
  ) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .dr_sel(dr_sel),
    .dr_tdo(dr_tdo), .dbg_wr_en(dbg_wr_en), .dbg_rd_en(dbg_rd_en),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  assign shifting = (state == ST_SHF_IR) || (state == ST_SHF_DR);
  assign tdo_d    = shifting ? ((state == ST_SHF_IR) ? ir_tdo : dr_tdo) : 1'b0;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= shifting;
    end
  end

  // R10: the output enable follows only the two shift states
  p_oe_in_shift_r10: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == ST_SHF_IR || state == ST_SHF_DR));
  // R10: a disabled output stays low
  p_tdo_quiet_r10: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_oe |-> !tdo);
endmodule

// File: tb/sim_dbg_tap_top.sv
module sim_dbg_tap_top;
  localparam logic [31:0] EXP_ID = 32'h0000_0675;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe, dbg_wr_en, dbg_rd_en;
  logic [7:0]  dbg_addr;
  logic [31:0] dbg_wdata, dbg_rdata;

  int n_chk = 0, n_bad = 0, wr_cnt = 0, rd_cnt = 0;
  bit done = 1'b0;

  logic [31:0] mem [256];
  logic [31:0] exp_mem [256];
  logic [31:0] exp_uc;

  always #4 tck = ~tck;

  dbg_tap_top u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .dbg_wr_en(dbg_wr_en), .dbg_rd_en(dbg_rd_en), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  assign dbg_rdata = mem[dbg_addr];
  always @(posedge tck) begin
    if (dbg_wr_en) mem[dbg_addr] <= dbg_wdata;
    if (dbg_wr_en) wr_cnt <= wr_cnt + 1;
    if (dbg_rd_en) rd_cnt <= rd_cnt + 1;
  end

  function automatic logic [31:0] seed_val(input int a);
    return (32'(a) * 32'h0101_0101) ^ 32'h5AC3_0000;
  endfunction
  function automatic bit is_ext(input logic [7:0] a);
    return (a != 8'h0B) && (a != 8'h0C);
  endfunction
  function automatic logic [31:0] exp_bypass(input logic [31:0] din);
    return {din[30:0], 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic tdo_s, oe_s, wr_s, rd_s;
  logic [7:0]  addr_s;
  logic [31:0] wdata_s;
  bit edge_bad;

  task automatic step(input logic m, input logic d);
    @(negedge tck); #2;
    tdo_s = tdo; oe_s = tdo_oe; wr_s = dbg_wr_en; rd_s = dbg_rd_en;
    addr_s = dbg_addr; wdata_s = dbg_wdata;
    tms = m; tdi = d;
    @(posedge tck); #1;
    if (tdo !== tdo_s) edge_bad = 1'b1;
  endtask

  bit oe_bad;
  logic cap_rd, upd_wr;
  logic [7:0]  upd_addr;
  logic [31:0] upd_data;

  task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    step(1'b1, 1'b0);
    if (oe_s !== 1'b0 || tdo_s !== 1'b0) oe_bad = 1'b1;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    cap_rd = rd_s;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      dout[i] = tdo_s;
      if (oe_s !== 1'b1) oe_bad = 1'b1;
    end
    step(1'b1, 1'b0);
    if (oe_s !== 1'b0) oe_bad = 1'b1;
    step(1'b0, 1'b0);
    upd_wr = wr_s; upd_addr = addr_s; upd_data = wdata_s;
  endtask

  task automatic set_ir(input logic [3:0] code);
    logic [3:0] got;
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, code[i]);
      got[i] = tdo_s;
    end
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk("R2 ir capture", 32'(got), 32'h1);
  endtask

  task automatic dbg_write(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] dout;
    int w0;
    set_ir(4'h5);
    shift_dr(8, 32'(a), dout);
    set_ir(4'h3);
    w0 = wr_cnt;
    shift_dr(32, d, dout);
    #1;
    if (is_ext(a)) begin
      chk("R7 write strobe", 32'(upd_wr), 32'h1);
      chk("R7 write addr", 32'(upd_addr), 32'(a));
      chk("R7 write data", upd_data, d);
      chk("R7 one write", 32'(wr_cnt - w0), 32'h1);
      exp_mem[a] = d;
    end else begin
      chk("R9 no write strobe", 32'(wr_cnt - w0), 32'h0);
      if (a == 8'h0C) exp_uc = d;
    end
  endtask

  task automatic dbg_read(input logic [7:0] a, output logic [31:0] dout);
    logic [31:0] tmp;
    int r0;
    set_ir(4'h5);
    shift_dr(8, 32'(a), tmp);
    set_ir(4'h4);
    r0 = rd_cnt;
    shift_dr(32, 32'h0, dout);
    if (is_ext(a)) begin
      chk("R8 read strobe", 32'(cap_rd), 32'h1);
      chk("R8 one read", 32'(rd_cnt - r0), 32'h1);
    end else begin
      chk("R9 no read strobe", 32'(rd_cnt - r0), 32'h0);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = seed_val(i);
      exp_mem[i] = seed_val(i);
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge tck);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] dout, din, rd;
    logic [7:0] a;
    logic [3:0] codes [10];
    exp_uc = 32'hFFFF_FFFF;
    oe_bad = 1'b0; edge_bad = 1'b0;
    codes = '{4'h0, 4'h1, 4'h2, 4'h6, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE};
    void'($urandom(32'd20240611));
    repeat (3) @(posedge tck);
    #1;
    chk("R10 reset oe", 32'(tdo_oe), 32'h0);
    chk("R10 reset tdo", 32'(tdo), 32'h0);
    chk("R11 reset strobes", 32'({dbg_wr_en, dbg_rd_en}), 32'h0);
    @(negedge tck); trst_n = 1'b1;
    step(1'b0, 1'b0);
    shift_dr(32, 32'hDEAD_BEEF, dout);
    chk("R1 id after trst", dout, EXP_ID);

    set_ir(4'h8);
    shift_dr(32, 32'h1234_5678, dout);
    chk("R5 usercode reset", dout, 32'hFFFF_FFFF);
    shift_dr(32, 32'hCAFE_0001, dout);
    chk("R5 usercode written", dout, 32'h1234_5678);
    exp_uc = 32'hCAFE_0001;

    set_ir(4'hF);
    din = 32'hA5F0_0F5A;
    shift_dr(32, din, dout);
    chk("R3 bypass", dout, exp_bypass(din));

    for (int k = 0; k < 10; k++) begin
      set_ir(codes[k]);
      din = $urandom;
      shift_dr(32, din, dout);
      chk("R4 unimplemented as bypass", dout, exp_bypass(din));
    end

    // TMS reset after five high clocks
    set_ir(4'hF);
    repeat (5) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    shift_dr(32, 32'h0, dout);
    chk("R1 id after tms reset", dout, EXP_ID);

    set_ir(4'h5);
    shift_dr(8, 32'h3C, dout);
    shift_dr(8, 32'h3C, dout);
    chk("R6 address capture", dout, 32'h3C);

    dbg_read(8'h0B, rd);
    chk("R9 read id addr", rd, EXP_ID);
    dbg_read(8'h0C, rd);
    chk("R9 read uc addr", rd, exp_uc);
    dbg_write(8'h0C, 32'h0BAD_F00D);
    set_ir(4'h8);
    shift_dr(32, exp_uc, dout);
    chk("R9 uc via debug write", dout, 32'h0BAD_F00D);
    dbg_write(8'h0B, 32'h1111_2222);
    dbg_read(8'h0B, rd);
    chk("R9 id write ignored", rd, EXP_ID);

    dbg_write(8'h00, 32'hFFFF_0000);
    dbg_read(8'hFF, rd);
    chk("R8 read top addr", rd, exp_mem[8'hFF]);
    dbg_read(8'h00, rd);
    chk("R8 read back addr 0", rd, 32'hFFFF_0000);

    for (int k = 0; k < 24; k++) begin
      a = 8'($urandom);
      din = $urandom;
      dbg_write(a, din);
      dbg_read(a, rd);
      if (a == 8'h0B) chk("R9 random id", rd, EXP_ID);
      else if (a == 8'h0C) chk("R9 random uc", rd, exp_uc);
      else chk("R8 random readback", rd, exp_mem[a]);
    end

    chk("R10 oe only in shift", 32'(oe_bad), 32'h0);
    chk("R10 tdo stable at rising edge", 32'(edge_bad), 32'h0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule